// File: doc/BRIEF.md
# Auto-acknowledging prioritized interrupt controller

This block collects a set of level-sensitive interrupt lines and hands them out to a small group of CPUs. Each source has a mask bit and a software-trigger bit. The trigger bit is ORed with the hardware line. Each source also has a target register that names the CPUs allowed to take it. Software configures the block over a simple 32-bit register bus. The bus offers set and clear bitmap banks for masks and triggers, a read-only view of the raw lines, an info word with the source count, and one target word per source.

Each CPU has its own event-read strobe. A read returns the lowest-numbered source that is pending, unmasked and targeted at that CPU. The same read also sets that source's mask bit, so the read acts as the acknowledge. Software re-enables the source with a mask clear at end of interrupt. When several CPUs read in the same cycle, the lower-numbered CPU chooses first. Higher CPUs never receive a source that a lower CPU has already claimed in that cycle.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A source is pending while its hardware line is high or its trigger bit is set. The pending state is level-based and persists across repeated delivery for as long as the cause stays.
- R2: An event read returns 32'h0001_nnnn: bits 23:16 hold kind 1 (hardware interrupt), bits 15:0 hold source number nnnn, and bits 31:24 are zero. It returns 0 when no source is pending, unmasked and targeted at that CPU.
- R3: Among the eligible sources, the event read returns the one with the lowest number.
- R4: A non-zero event read sets the returned source's mask bit at the same clock edge. If a mask-clear write for that source lands on the same edge, the mask stays set.
- R5: Source n lives in word n>>5, bit n&31 of each bitmap bank. The banks are mask-set at byte 0x080+4w, mask-clear at 0x100+4w, trigger-set at 0x180+4w and trigger-clear at 0x200+4w. Writing 1 acts, writing 0 leaves the bit alone, and reading either address of a pair returns the current bitmap. Accesses with address bits 1:0 not zero are ignored and read as 0.
- R6: The target word of source n is at byte 0x400+4n and holds one bit per CPU in bits NUM_CPU-1:0. Higher written bits are dropped and read as 0. A source is offered only to CPUs whose bit is set.
- R7: When CPUs read in the same cycle, they are served in ascending CPU order. Each CPU takes the lowest eligible source that no lower CPU took in that cycle, so two CPUs never receive the same source.
- R8: The info word at byte 0x000 returns the number of implemented sources in bits 15:0, with the other bits zero.
- R9: After reset, every mask bit is 1, every trigger bit is 0, every target word is 1 (CPU 0), and every event output is 0.
- R10: The raw-state bank at byte 0x280+4w returns the hardware lines alone, without the trigger bits.
- R11: Bus read data and the event word are registered. They are valid from the first clock edge after the request and hold until the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_irq | input | NUM_SRC | Level-sensitive hardware interrupt lines |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| evt_req | input | NUM_CPU | Per-CPU event read (acknowledge) strobe |
| evt_word | output | 32*NUM_CPU | Per-CPU registered event word, CPU c in bits 32c+31:32c |

## Verification
The selection is exercised in several ways: a single trigger-bit source, two hardware lines pending together, a source aimed only at a non-zero CPU, and two CPUs reading in the same cycle over a shared pair. These cases separate lowest-number priority, target filtering and the CPU-order claim chain from one another. A repeated read of a source whose cause is still present tells the level behaviour apart from one-shot latching. A mask clear on the same edge as the acknowledge shows which update wins. A long seeded random mix of line changes, bank writes, target rewrites and multi-CPU reads is compared against a bench model of the requirements. This mix catches errors in word or bit placement and in set/clear behaviour that the directed cases leave out.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int WORD_W = 32;
  localparam logic [7:0] EVT_KIND_HWIRQ = 8'd1;

  typedef enum logic [2:0] {
    BK_INFO     = 3'd0,
    BK_MASK_SET = 3'd1,
    BK_MASK_CLR = 3'd2,
    BK_TRIG_SET = 3'd3,
    BK_TRIG_CLR = 3'd4,
    BK_RAW      = 3'd5
  } bank_e;

  function automatic logic [WORD_W-1:0] evt_pack(input logic [15:0] src);
    return {8'd0, EVT_KIND_HWIRQ, src};
  endfunction
endpackage

// File: rtl/pic_prienc.sv
// Lowest-index-wins priority encoder.
module pic_prienc #(
  parameter int N  = 64,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  output logic          hit,
  output logic [IW-1:0] idx
);
  always_comb begin
    hit = |vec;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/pic_select.sv
// Per-CPU winner selection; lower CPUs claim first within one cycle.
module pic_select #(
  parameter int NUM_SRC = 64,
  parameter int NUM_CPU = 4,
  parameter int IW      = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]         ready,
  input  logic [NUM_SRC*NUM_CPU-1:0] tgt_flat,
  input  logic [NUM_CPU-1:0]         req,
  output logic [NUM_CPU-1:0]         win,
  output logic [NUM_CPU*IW-1:0]      win_idx,
  output logic [NUM_SRC-1:0]         claim
);
  logic [NUM_CPU:0][NUM_SRC-1:0] taken;
  assign taken[0] = '0;

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic [NUM_SRC-1:0] col;
    logic [NUM_SRC-1:0] cand;
    logic               hit;
    logic [IW-1:0]      idx;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_col
      assign col[s] = tgt_flat[s*NUM_CPU + c];
    end

    assign cand = ready & col & ~taken[c];

    pic_prienc #(.N(NUM_SRC), .IW(IW)) u_enc (
      .vec (cand),
      .hit (hit),
      .idx (idx)
    );

    assign win[c]               = req[c] & hit;
    assign win_idx[c*IW +: IW]  = idx;
    assign taken[c+1]           = taken[c] | (win[c] ? (NUM_SRC'(1) << idx) : '0);
  end

  assign claim = taken[NUM_CPU];
endmodule

// File: rtl/pic_regs.sv
// Register bank: mask/trigger bitmaps, target words, registered read mux.
// NUM_SRC must be a multiple of 32.
module pic_regs
  import pic_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 12
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bus_we,
  input  logic                       bus_re,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [WORD_W-1:0]          bus_wdata,
  output logic [WORD_W-1:0]          bus_rdata,
  input  logic [NUM_SRC-1:0]         hw_irq,
  input  logic [NUM_SRC-1:0]         claim,
  output logic [NUM_SRC-1:0]         mask,
  output logic [NUM_SRC-1:0]         trig,
  output logic [NUM_SRC*NUM_CPU-1:0] tgt_flat
);
  localparam int NW = NUM_SRC / WORD_W;
  localparam int IW = $clog2(NUM_SRC);
  localparam int RW = ADDR_W - 10;

  logic [NUM_SRC-1:0][NUM_CPU-1:0] tgt;
  logic                aligned, in_bank, in_tgt, tgt_hit, word_hit;
  logic [RW-1:0]       region;
  bank_e               bank;
  logic [4:0]          widx;
  logic [7:0]          tidx;
  logic [NUM_SRC-1:0]  mset, mclr, tset, tclr;
  logic [WORD_W-1:0]   rd_val;

  assign aligned  = (bus_addr[1:0] == 2'b00);
  assign region   = bus_addr[ADDR_W-1:10];
  assign bank     = bank_e'(bus_addr[9:7]);
  assign widx     = bus_addr[6:2];
  assign tidx     = bus_addr[9:2];
  assign in_bank  = aligned && (region == '0);
  assign in_tgt   = aligned && (region == RW'(1));
  assign tgt_hit  = in_tgt && (int'(tidx) < NUM_SRC);
  assign word_hit = in_bank && (int'(widx) < NW);

  // write decode into per-source set/clear vectors
  always_comb begin
    mset = '0; mclr = '0; tset = '0; tclr = '0;
    if (bus_we && word_hit) begin
      for (int w = 0; w < NW; w++) begin
        if (widx == 5'(w)) begin
          case (bank)
            BK_MASK_SET: mset[w*WORD_W +: WORD_W] = bus_wdata;
            BK_MASK_CLR: mclr[w*WORD_W +: WORD_W] = bus_wdata;
            BK_TRIG_SET: tset[w*WORD_W +: WORD_W] = bus_wdata;
            BK_TRIG_CLR: tclr[w*WORD_W +: WORD_W] = bus_wdata;
            default: ;
          endcase
        end
      end
    end
  end

  // the acknowledge claim is applied last so it wins over a clear
  always_ff @(posedge clk) begin
    if (rst) begin
      mask <= '1;
      trig <= '0;
    end else begin
      mask <= ((mask | mset) & ~mclr) | claim;
      trig <= (trig | tset) & ~tclr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NUM_SRC; s++) tgt[s] <= NUM_CPU'(1);
    end else if (bus_we && tgt_hit) begin
      tgt[tidx[IW-1:0]] <= bus_wdata[NUM_CPU-1:0];
    end
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_flat
    assign tgt_flat[s*NUM_CPU +: NUM_CPU] = tgt[s];
  end

  always_comb begin
    rd_val = '0;
    if (tgt_hit) begin
      rd_val = WORD_W'(tgt[tidx[IW-1:0]]);
    end else if (word_hit) begin
      for (int w = 0; w < NW; w++) begin
        if (widx == 5'(w)) begin
          case (bank)
            BK_INFO:     rd_val = (w == 0) ? {16'd0, 16'(NUM_SRC)} : '0;
            BK_MASK_SET,
            BK_MASK_CLR: rd_val = mask[w*WORD_W +: WORD_W];
            BK_TRIG_SET,
            BK_TRIG_CLR: rd_val = trig[w*WORD_W +: WORD_W];
            BK_RAW:      rd_val = hw_irq[w*WORD_W +: WORD_W];
            default:     rd_val = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_val;
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 12
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_SRC-1:0]          hw_irq,
  input  logic                        bus_we,
  input  logic                        bus_re,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [31:0]                 bus_wdata,
  output logic [31:0]                 bus_rdata,
  input  logic [NUM_CPU-1:0]          evt_req,
  output logic [NUM_CPU*32-1:0]       evt_word
);
  localparam int IW = $clog2(NUM_SRC);

  logic [NUM_SRC-1:0]         mask_bits, trig_bits, pend, claim;
  logic [NUM_SRC*NUM_CPU-1:0] tgt_flat;
  logic [NUM_CPU-1:0]         win;
  logic [NUM_CPU*IW-1:0]      win_idx;

  assign pend = hw_irq | trig_bits;

  pic_regs #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .hw_irq    (hw_irq),
    .claim     (claim),
    .mask      (mask_bits),
    .trig      (trig_bits),
    .tgt_flat  (tgt_flat)
  );

  pic_select #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .IW(IW)) u_sel (
    .ready    (pend & ~mask_bits),
    .tgt_flat (tgt_flat),
    .req      (evt_req),
    .win      (win),
    .win_idx  (win_idx),
    .claim    (claim)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_word <= '0;
    end else begin
      for (int c = 0; c < NUM_CPU; c++) begin
        if (evt_req[c])
          evt_word[c*32 +: 32] <= win[c] ? evt_pack(16'(win_idx[c*IW +: IW])) : 32'd0;
      end
    end
  end
endmodule

// File: rtl/pic_chk.sv
module pic_chk #(
  parameter int NUM_SRC = 64,
  parameter int NUM_CPU = 4
) (
  input logic                        clk,
  input logic                        rst,
  input logic [NUM_CPU-1:0]          evt_req,
  input logic [NUM_CPU*32-1:0]       evt_word,
  input logic [NUM_SRC-1:0]          mask,
  input logic [NUM_SRC-1:0]          pend,
  input logic [NUM_SRC*NUM_CPU-1:0]  tgt_flat
);
  localparam int IW = $clog2(NUM_SRC);

  logic [NUM_CPU-1:0] req_d;
  always_ff @(posedge clk) begin
    if (rst) req_d <= '0;
    else     req_d <= evt_req;
  end

  // R9
  assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (&mask && evt_word == '0))
    else $error("reset_state_chk");

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_c
    logic [NUM_SRC-1:0] col, elig_q;
    logic [31:0]        w;
    logic [IW-1:0]      sidx;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_col
      assign col[s] = tgt_flat[s*NUM_CPU + c];
    end
    assign w    = evt_word[c*32 +: 32];
    assign sidx = w[IW-1:0];

    always_ff @(posedge clk) begin
      if (rst) elig_q <= '0;
      else     elig_q <= pend & ~mask & col;
    end

    // R2
    assert property (@(posedge clk) disable iff (rst)
      (w == 32'd0) || (w[31:16] == 16'h0001 && int'(w[15:0]) < NUM_SRC))
      else $error("evt_fmt_chk");

    // R6
    assert property (@(posedge clk) disable iff (rst)
      (req_d[c] && w != 32'd0) |-> elig_q[sidx])
      else $error("evt_elig_chk");

    // R4
    assert property (@(posedge clk) disable iff (rst)
      (req_d[c] && w != 32'd0) |-> mask[sidx])
      else $error("auto_mask_chk");

    if (c == 0) begin : g_first
      // R3
      assert property (@(posedge clk) disable iff (rst)
        (req_d[0] && w != 32'd0) |-> ((elig_q & ((NUM_SRC'(1) << sidx) - NUM_SRC'(1))) == '0))
        else $error("lowest_wins_chk");

      // R2
      assert property (@(posedge clk) disable iff (rst)
        (req_d[0] && elig_q != '0) |-> (w != 32'd0))
        else $error("no_lost_evt_chk");
    end

    for (genvar d = c + 1; d < NUM_CPU; d++) begin : g_pair
      // R7
      assert property (@(posedge clk) disable iff (rst)
        (req_d[c] && req_d[d] && w != 32'd0 && evt_word[d*32 +: 32] != 32'd0)
          |-> (w[15:0] != evt_word[d*32 +: 16]))
        else $error("distinct_claim_chk");
    end
  end
endmodule

bind prio_irq_ctrl pic_chk #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .evt_req  (evt_req),
  .evt_word (evt_word),
  .mask     (mask_bits),
  .pend     (pend),
  .tgt_flat (tgt_flat)
);

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
  localparam int NS = 64;
  localparam int NC = 4;
  localparam int AW = 12;
  localparam logic [AW-1:0] A_INFO = 12'h000, A_MSET = 12'h080, A_MCLR = 12'h100,
                            A_TSET = 12'h180, A_TCLR = 12'h200, A_RAW = 12'h280,
                            A_TGT = 12'h400;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [NS-1:0]    hw_irq = '0;
  logic             bus_we = 1'b0, bus_re = 1'b0;
  logic [AW-1:0]    bus_addr = '0;
  logic [31:0]      bus_wdata = '0;
  wire  [31:0]      bus_rdata;
  logic [NC-1:0]    evt_req = '0;
  wire  [NC*32-1:0] evt_word;

  prio_irq_ctrl #(.NUM_SRC(NS), .NUM_CPU(NC), .ADDR_W(AW)) i_prio_irq_ctrl (
    .clk(clk), .rst(rst), .hw_irq(hw_irq), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_req(evt_req), .evt_word(evt_word)
  );

  int checks = 0;
  int errors = 0;
  bit [NS-1:0]  m_mask = '1;
  bit [NS-1:0]  m_trig = '0;
  bit [NC-1:0]  m_tgt [NS];
  logic [31:0]  exp_evt [NC];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // bench model of a bus write, from the address map in R5, R6
  task automatic model_write(input logic [AW-1:0] a, input logic [31:0] d);
    int w;
    if (a[1:0] != 2'b00) return;
    if (a[11:10] == 2'd1) begin
      if (int'(a[9:2]) < NS) m_tgt[a[9:2]] = d[NC-1:0];
      return;
    end
    if (a[11:10] != 2'd0) return;
    w = int'(a[6:2]);
    if (w >= NS / 32) return;
    case (a[9:7])
      3'd1: m_mask[w*32 +: 32] = m_mask[w*32 +: 32] | d;
      3'd2: m_mask[w*32 +: 32] = m_mask[w*32 +: 32] & ~d;
      3'd3: m_trig[w*32 +: 32] = m_trig[w*32 +: 32] | d;
      3'd4: m_trig[w*32 +: 32] = m_trig[w*32 +: 32] & ~d;
      default: ;
    endcase
  endtask

  // bench model of event selection (R1, R3, R4, R6, R7)
  task automatic model_events(input logic [NC-1:0] req);
    bit [NS-1:0] taken = '0;
    for (int c = 0; c < NC; c++) begin
      if (req[c]) begin
        exp_evt[c] = 32'd0;
        for (int s = 0; s < NS; s++) begin
          if ((hw_irq[s] | m_trig[s]) && !m_mask[s] && m_tgt[s][c] && !taken[s]) begin
            exp_evt[c] = 32'h0001_0000 | 32'(s);
            taken[s] = 1'b1;
            break;
          end
        end
      end
    end
    m_mask = m_mask | taken;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    model_write(a, d);
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_re = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_re = 1'b0;
    check(tag, bus_rdata, exp);
  endtask

  task automatic evt(input logic [NC-1:0] req, input string tag);
    @(negedge clk);
    model_events(req);
    evt_req = req;
    @(negedge clk);
    evt_req = '0;
    for (int c = 0; c < NC; c++)
      if (req[c]) check(tag, evt_word[c*32 +: 32], exp_evt[c]);
  endtask

  initial begin
    #(20 * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int s = 0; s < NS; s++) m_tgt[s] = 1;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R9 reset state
    rd(A_MSET, 32'hFFFF_FFFF, "R9 mask word0");
    rd(A_MCLR + 4, 32'hFFFF_FFFF, "R9 mask word1");
    rd(A_TSET, 32'h0, "R9 trig word0");
    rd(A_TGT + 4*63, 32'h1, "R9 target 63");
    check("R9 event outputs", evt_word[31:0] | evt_word[63:32] | evt_word[95:64] | evt_word[127:96], 32'h0);
    // R8 info
    rd(A_INFO, 32'd64, "R8 info");

    // R2 / R11 trigger-bit source
    wr(A_TSET, 32'h1 << 5);
    wr(A_MCLR, 32'h1 << 5);
    evt(4'b0001, "R2 single source");
    check("R2 word value", evt_word[31:0], 32'h0001_0005);
    rd(A_MSET, 32'hFFFF_FFFF, "R4 masked after read");
    evt(4'b0001, "R2 empty returns zero");
    // R1 level: cause still set, re-enable delivers again
    wr(A_MCLR, 32'h1 << 5);
    evt(4'b0001, "R1 level redelivery");
    wr(A_TCLR, 32'h1 << 5);
    wr(A_MCLR, 32'h1 << 5);
    evt(4'b0001, "R1 cleared cause");

    // R3 two hardware lines, R10 raw view
    @(negedge clk);
    hw_irq[40] = 1'b1; hw_irq[3] = 1'b1;
    rd(A_RAW, 32'h1 << 3, "R10 raw word0");
    rd(A_RAW + 4, 32'h1 << 8, "R10 raw word1");
    rd(A_TSET + 4, 32'h0, "R10 trig not raw");
    wr(A_MCLR, 32'h1 << 3);
    wr(A_MCLR + 4, 32'h1 << 8);
    evt(4'b0001, "R3 lowest first");
    evt(4'b0001, "R3 next after ack");
    @(negedge clk);
    hw_irq = '0;

    // R6 targeting and dropped upper bits
    wr(A_TGT + 4*10, 32'hFFFF_FFF4);
    rd(A_TGT + 4*10, 32'h4, "R6 target readback");
    wr(A_TSET, 32'h1 << 10);
    wr(A_MCLR, 32'h1 << 10);
    evt(4'b0001, "R6 not offered to cpu0");
    evt(4'b0100, "R6 offered to cpu2");

    // R7 simultaneous reads
    wr(A_TGT + 4*7, 32'h3);
    wr(A_TGT + 4*8, 32'h3);
    wr(A_TSET, (32'h1 << 7) | (32'h1 << 8));
    wr(A_MCLR, (32'h1 << 7) | (32'h1 << 8));
    evt(4'b0011, "R7 cpu order");

    // R5 zero write and unaligned access have no effect
    wr(A_MCLR, 32'h0);
    rd(A_MCLR, m_mask[31:0], "R5 zero write");
    wr(A_MCLR + 1, 32'hFFFF_FFFF);
    rd(A_MSET, m_mask[31:0], "R5 unaligned write ignored");
    rd(A_MSET + 2, 32'h0, "R5 unaligned read");

    // R4 clear landing on the acknowledge edge
    wr(A_TSET, 32'h1 << 12);
    wr(A_MCLR, 32'h1 << 12);
    @(negedge clk);
    model_events(4'b0001);
    bus_we = 1'b1; bus_addr = A_MCLR; bus_wdata = 32'h1 << 12; evt_req = 4'b0001;
    @(negedge clk);
    bus_we = 1'b0; evt_req = '0;
    check("R4 same-edge event", evt_word[31:0], exp_evt[0]);
    rd(A_MSET, m_mask[31:0], "R4 mask wins over clear");
    wr(A_TCLR, 32'hFFFF_FFFF);

    // seeded random mix against the model
    for (int i = 0; i < 600; i++) begin
      int op;
      logic [31:0] d;
      op = int'($urandom_range(0, 6));
      d = $urandom & $urandom;
      case (op)
        0: begin
          @(negedge clk);
          hw_irq = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
        end
        1: wr(A_MSET + 4 * AW'($urandom_range(0, 1)), d & $urandom);
        2: wr(A_MCLR + 4 * AW'($urandom_range(0, 1)), d);
        3: wr(($urandom_range(0, 1) ? A_TSET : A_TCLR) + 4 * AW'($urandom_range(0, 1)), d);
        4: wr(A_TGT + 4 * AW'($urandom_range(0, NS - 1)), $urandom);
        5: evt(NC'($urandom), "R3 R7 random events");
        default: begin
          int w;
          w = int'($urandom_range(0, 1));
          rd(A_MSET + 4 * AW'(w), m_mask[w*32 +: 32], "R5 random mask readback");
        end
      endcase
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule